// File: doc/BRIEF.md
# External Bus Chip-Select Decoder

This block turns a bus address into one of up to four active-low chip selects for an external memory and peripheral bus. Three address regions can be enabled through a 12-bit mapping word: a RAM region, a peripheral region and a code region. Each region has a 2-bit base selector, where zero disables the region, and a 2-bit size selector. A 2-bit chip-select mode input picks how the enabled regions are spread over the chip selects. In single mode everything goes to CS0. In dual mode one region is split in half between CS0 and CS1, or two regions get one chip select each. In quad mode four fixed 512 MB windows each get their own chip select.

The chip selects, a decode-miss flag and the multiplexed/non-multiplexed bus mode of the selected chip select are registered. They appear one clock after the address is presented with its valid strobe. Configuration inputs are treated as static. The timing engine, the data path and register access sit outside this block.

Top module: `ebus_cs_decoder`

## Requirements
- R1: Mapping word fields, least significant first: [1:0] RAM base select, [3:2] RAM size, [5:4] peripheral base select, [7:6] peripheral size, [9:8] code base select, [11:10] code size. A select of 0 disables its region. RAM bases: select 1 or 3 gives 0x60000000 and select 2 gives 0x80000000. Peripheral bases: select 1 or 3 gives 0xA0000000 and select 2 gives 0xC0000000. Any nonzero code select gives 0x10000000. A size code of 0, 1, 2 or 3 gives a window of 2^8, 2^16, 2^24 or 2^28 bytes. An address hits a region when it matches the base on all bits at and above log2(size).
- R2: Mode input 0 or 3, or any configuration that matches no rule of R3 to R7, is single mode: a hit in any enabled region asserts CS0 only.
- R3: Mode 1 (dual) with only the peripheral select nonzero: a peripheral hit asserts CS0 when address bit log2(size)-1 is 0 and CS1 when it is 1.
- R4: Mode 1 with only the RAM select nonzero: a RAM hit is split between CS0 and CS1 by address bit log2(size)-1, in the same way as R3.
- R5: Mode 1 with peripheral and RAM selects both nonzero and the code select zero: a peripheral hit asserts CS0 and a RAM hit asserts CS1.
- R6: Mode 1 with code select 1 and exactly one of the peripheral or RAM selects nonzero: a code hit asserts CS0 and a hit in the other enabled region asserts CS1.
- R7: Mode 2 (quad) with RAM select 3, peripheral select 3 and code select 0: address bits [31:29] equal to 3, 4, 5 or 6 assert CS0, CS1, CS2 or CS3, and the size fields have no effect. Mode 2 with any other selects behaves as R2.
- R8: The bus-mode output is bus_mode_i[n] for asserted chip select n when mode_per_cs_i is 1, and bus_mode_i[0] when it is 0. It is 0 when no chip select is asserted.
- R9: Outputs are registered with one clock of latency. A cycle with addr_vld_i low yields all chip selects high and miss_o low.
- R10: A valid address that hits no window yields all chip selects high and miss_o high.
- R11: During reset (rst_n low at the clock edge) all chip selects are high, and miss_o and mux_mode_o are 0.
- R12: At most one chip select is low at any time, and CS2 and CS3 are asserted only by R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 32 | Bus address |
| addr_vld_i | input | 1 | Address valid strobe |
| map_cfg_i | input | 12 | Region mapping word (R1 layout) |
| cs_mode_i | input | 2 | 0 single, 1 dual, 2 quad, 3 single |
| bus_mode_i | input | 4 | Per-chip-select bus mode, 1 = multiplexed |
| mode_per_cs_i | input | 1 | 1 = use each chip select's own bus mode |
| cs_n_o | output | 4 | Active-low chip selects |
| mux_mode_o | output | 1 | Bus mode of the asserted chip select |
| miss_o | output | 1 | Valid address decoded to no window |

## Verification
The bench builds the decoder with its default parameters: a 32-bit address, four chip selects, a 12-bit mapping word and 512 MB quad windows starting at window index 3. Because the configuration space is small, it sweeps every mode code, all 64 combinations of the three base selectors, and four rotations of the size fields. That covers every dual rule, every legal and illegal quad setting, and the fallback to single mode. For each configuration it probes both ends and the split point of every region window, the first byte past each window, and the edges of the quad windows. Every point is checked against an arithmetic model of the rules, together with the bus-mode selection and the idle and reset behaviour.

// File: rtl/ebus_cs_pkg.sv
// Package: shared types and address-map helpers for the chip-select decoder.
// Assumes a 32-bit address space; region bases are fixed constants.
package ebus_cs_pkg;

    localparam int NUM_REGION = 3;
    localparam int IDX_RAM    = 0;
    localparam int IDX_PERIPH = 1;
    localparam int IDX_CODE   = 2;
    localparam int FIELD_W    = 2;
    localparam int REGION_W   = 2 * FIELD_W;

    typedef enum logic [1:0] {
        CSM_SINGLE = 2'd0,
        CSM_DUAL   = 2'd1,
        CSM_QUAD   = 2'd2,
        CSM_SPARE  = 2'd3
    } cs_mode_e;

    // One region's slice of the mapping word: size above, base select below.
    typedef struct packed {
        logic [FIELD_W-1:0] size;
        logic [FIELD_W-1:0] sel;
    } region_cfg_t;

    // Base address of a region for a given nonzero base select.
    function automatic logic [31:0] region_base(input int kind, input logic [FIELD_W-1:0] sel);
        logic [31:0] b;
        if (kind == IDX_RAM) begin
            b = (sel == 2'd2) ? 32'h8000_0000 : 32'h6000_0000;
        end else if (kind == IDX_PERIPH) begin
            b = (sel == 2'd2) ? 32'hC000_0000 : 32'hA000_0000;
        end else begin
            b = 32'h1000_0000;
        end
        return b;
    endfunction

    // log2 of the window size for a size code.
    function automatic logic [4:0] size_shift(input logic [FIELD_W-1:0] size);
        logic [4:0] s;
        case (size)
            2'd0:    s = 5'd8;
            2'd1:    s = 5'd16;
            2'd2:    s = 5'd24;
            default: s = 5'd28;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ebus_region_match.sv
// Module: window match for one address region.
// Reports whether the address falls in the region's enabled window and the
// value of the window's top address bit (used for splitting in dual mode).
// Assumes ADDR_W of 32 so the fixed bases fit.
module ebus_region_match
    import ebus_cs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KIND   = 0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  region_cfg_t       cfg_i,
    output logic              hit_o,
    output logic              upper_o
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
    logic [4:0]        shift;

    // Purpose: compare address against the region base above the window size.
    always_comb begin
        base  = region_base(KIND, cfg_i.sel);
        shift = size_shift(cfg_i.size);
        mask  = {ADDR_W{1'b1}} << shift;
        hit_o = (cfg_i.sel != '0) && (((addr_i ^ base) & mask) == '0);
    end

    // Purpose: pick the most significant address bit inside the window.
    always_comb begin
        case (cfg_i.size)
            2'd0:    upper_o = addr_i[7];
            2'd1:    upper_o = addr_i[15];
            2'd2:    upper_o = addr_i[23];
            default: upper_o = addr_i[27];
        endcase
    end

endmodule

// File: rtl/ebus_cs_rules.sv
// Module: chip-select assignment rules.
// Turns region hits, split bits and the mode into a one-hot chip-select vector.
// Assumes NUM_CS >= 2; quad windows are contiguous starting at QUAD_FIRST.
module ebus_cs_rules
    import ebus_cs_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int TOP_W      = 3,
    parameter int QUAD_FIRST = 3
) (
    input  cs_mode_e               mode_i,
    input  logic [FIELD_W-1:0]     sel_ram_i,
    input  logic [FIELD_W-1:0]     sel_per_i,
    input  logic [FIELD_W-1:0]     sel_code_i,
    input  logic [NUM_REGION-1:0]  hit_i,
    input  logic [NUM_REGION-1:0]  upper_i,
    input  logic [TOP_W-1:0]       addr_top_i,
    output logic [NUM_CS-1:0]      cs_oh_o
);

    logic [NUM_CS-1:0] qwin_hit;
    logic quad_ok;
    logic per_on, ram_on, code_off;
    logic dual_per_only, dual_ram_only, dual_both, dual_code;
    logic unused_code_upper;

    assign unused_code_upper = upper_i[IDX_CODE];

    // Purpose: fixed quad windows, one per chip select.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_qwin
        assign qwin_hit[g] = (addr_top_i == TOP_W'(QUAD_FIRST + g));
    end

    // Purpose: classify the region-select combination.
    always_comb begin
        per_on        = (sel_per_i != '0);
        ram_on        = (sel_ram_i != '0);
        code_off      = (sel_code_i == '0);
        quad_ok       = (mode_i == CSM_QUAD) && (sel_ram_i == 2'd3) &&
                        (sel_per_i == 2'd3) && code_off;
        dual_per_only = per_on && !ram_on && code_off;
        dual_ram_only = ram_on && !per_on && code_off;
        dual_both     = per_on && ram_on && code_off;
        dual_code     = (sel_code_i == 2'd1) && (per_on ^ ram_on);
    end

    // Purpose: assign the chip select according to the active rule.
    always_comb begin
        cs_oh_o = '0;
        if (quad_ok) begin
            cs_oh_o = qwin_hit;
        end else if (mode_i == CSM_DUAL && dual_per_only) begin
            cs_oh_o[0] = hit_i[IDX_PERIPH] && !upper_i[IDX_PERIPH];
            cs_oh_o[1] = hit_i[IDX_PERIPH] &&  upper_i[IDX_PERIPH];
        end else if (mode_i == CSM_DUAL && dual_ram_only) begin
            cs_oh_o[0] = hit_i[IDX_RAM] && !upper_i[IDX_RAM];
            cs_oh_o[1] = hit_i[IDX_RAM] &&  upper_i[IDX_RAM];
        end else if (mode_i == CSM_DUAL && dual_both) begin
            cs_oh_o[0] = hit_i[IDX_PERIPH];
            cs_oh_o[1] = hit_i[IDX_RAM];
        end else if (mode_i == CSM_DUAL && dual_code) begin
            cs_oh_o[0] = hit_i[IDX_CODE];
            cs_oh_o[1] = hit_i[IDX_RAM] || hit_i[IDX_PERIPH];
        end else begin
            cs_oh_o[0] = |hit_i;
        end
    end

endmodule

// File: rtl/ebus_bus_mode_pick.sv
// Module: bus-mode selection for the asserted chip select.
// Assumes cs_oh_i is one-hot or zero.
module ebus_bus_mode_pick #(
    parameter int NUM_CS = 4
) (
    input  logic [NUM_CS-1:0] cs_oh_i,
    input  logic [NUM_CS-1:0] bus_mode_i,
    input  logic              per_cs_i,
    output logic              mux_o
);

    // Purpose: take the own or shared mode of the chip select that fires.
    always_comb begin
        mux_o = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (cs_oh_i[i]) begin
                mux_o = per_cs_i ? bus_mode_i[i] : bus_mode_i[0];
            end
        end
    end

endmodule

// File: rtl/ebus_cs_decoder.sv
// Module: external bus chip-select decoder (top).
// Decodes a valid address into registered active-low chip selects, a miss
// flag and the bus mode of the selected chip select. Configuration inputs
// are assumed static while addresses are decoded.
module ebus_cs_decoder
    import ebus_cs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_CS     = 4,
    parameter int QUAD_SHIFT = 29,
    parameter int QUAD_FIRST = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          addr_vld_i,
    input  logic [NUM_REGION*REGION_W-1:0] map_cfg_i,
    input  logic [1:0]                    cs_mode_i,
    input  logic [NUM_CS-1:0]             bus_mode_i,
    input  logic                          mode_per_cs_i,
    output logic [NUM_CS-1:0]             cs_n_o,
    output logic                          mux_mode_o,
    output logic                          miss_o
);

    localparam int TOP_W = ADDR_W - QUAD_SHIFT;

    region_cfg_t           rcfg [NUM_REGION];
    logic [NUM_REGION-1:0] hit;
    logic [NUM_REGION-1:0] upper;
    logic [NUM_CS-1:0]     cs_oh;
    logic                  mux_c;

    // Purpose: one window matcher per region slice of the mapping word.
    for (genvar g = 0; g < NUM_REGION; g++) begin : g_region
        assign rcfg[g] = map_cfg_i[g*REGION_W +: REGION_W];
        ebus_region_match #(
            .ADDR_W (ADDR_W),
            .KIND   (g)
        ) i_match (
            .addr_i  (addr_i),
            .cfg_i   (rcfg[g]),
            .hit_o   (hit[g]),
            .upper_o (upper[g])
        );
    end

    ebus_cs_rules #(
        .NUM_CS     (NUM_CS),
        .TOP_W      (TOP_W),
        .QUAD_FIRST (QUAD_FIRST)
    ) i_rules (
        .mode_i     (cs_mode_e'(cs_mode_i)),
        .sel_ram_i  (rcfg[IDX_RAM].sel),
        .sel_per_i  (rcfg[IDX_PERIPH].sel),
        .sel_code_i (rcfg[IDX_CODE].sel),
        .hit_i      (hit),
        .upper_i    (upper),
        .addr_top_i (addr_i[ADDR_W-1:QUAD_SHIFT]),
        .cs_oh_o    (cs_oh)
    );

    ebus_bus_mode_pick #(
        .NUM_CS (NUM_CS)
    ) i_mode (
        .cs_oh_i    (cs_oh),
        .bus_mode_i (bus_mode_i),
        .per_cs_i   (mode_per_cs_i),
        .mux_o      (mux_c)
    );

    // Purpose: register outputs; idle and reset drive all selects high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_o     <= '1;
            miss_o     <= 1'b0;
            mux_mode_o <= 1'b0;
        end else if (addr_vld_i) begin
            cs_n_o     <= ~cs_oh;
            miss_o     <= ~|cs_oh;
            mux_mode_o <= mux_c;
        end else begin
            cs_n_o     <= '1;
            miss_o     <= 1'b0;
            mux_mode_o <= 1'b0;
        end
    end

    // R12: never more than one chip select low.
    a_r12_onehot_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R9: an idle strobe leaves every select high and no miss next cycle.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld_i |=> (cs_n_o == '1) && !miss_o);

    // R10: a miss is never reported together with an asserted select.
    a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (cs_n_o == '1) && !mux_mode_o);

    // R7: last quad window drives the last chip select in legal quad mode.
    a_r7_quad_last: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_i && cs_mode_i == CSM_QUAD && map_cfg_i[1:0] == 2'd3 &&
         map_cfg_i[5:4] == 2'd3 && map_cfg_i[9:8] == 2'd0 &&
         addr_i[ADDR_W-1:QUAD_SHIFT] == TOP_W'(QUAD_FIRST + NUM_CS - 1))
        |=> !cs_n_o[NUM_CS-1]);

    // R12: upper chip selects stay high outside quad mode.
    a_r12_upper_quad_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_mode_i != CSM_QUAD) |=> (cs_n_o[NUM_CS-1:2] == '1));

endmodule

// File: tb/test_ebus_cs_decoder.sv
`timescale 1ns/1ps
// Bench: sweeps modes, base selects and size rotations against an
// arithmetic model of the decode rules.
module test_ebus_cs_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        vld = 1'b0;
    logic [11:0] map = '0;
    logic [1:0]  mode = '0;
    logic [3:0]  bmode = '0;
    logic        per_en = 1'b0;
    logic [3:0]  cs_n;
    logic        mux;
    logic        miss;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ebus_cs_decoder i_ebus_cs_decoder (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_i        (addr),
        .addr_vld_i    (vld),
        .map_cfg_i     (map),
        .cs_mode_i     (mode),
        .bus_mode_i    (bmode),
        .mode_per_cs_i (per_en),
        .cs_n_o        (cs_n),
        .mux_mode_o    (mux),
        .miss_o        (miss)
    );

    function automatic logic [31:0] base_of(input int kind, input logic [1:0] s);
        if (kind == 0) return (s == 2) ? 32'h8000_0000 : 32'h6000_0000;
        if (kind == 1) return (s == 2) ? 32'hC000_0000 : 32'hA000_0000;
        return 32'h1000_0000;
    endfunction

    function automatic int shift_of(input logic [1:0] z);
        return (z == 3) ? 28 : 8 + 8 * int'(z);
    endfunction

    // Model of R1..R7: returns the expected chip select, or -1 for none.
    function automatic int ref_cs(input logic [1:0] m, input logic [11:0] w,
                                  input logic [31:0] a, output string tag);
        logic [1:0] sr, sp, sc;
        bit hr, hp, hc, ur, up;
        int sh;
        sr = w[1:0]; sp = w[5:4]; sc = w[9:8];
        sh = shift_of(w[3:2]);
        hr = (sr != 0) && ((a >> sh) == (base_of(0, sr) >> sh));
        ur = a[sh-1];
        sh = shift_of(w[7:6]);
        hp = (sp != 0) && ((a >> sh) == (base_of(1, sp) >> sh));
        up = a[sh-1];
        sh = shift_of(w[11:10]);
        hc = (sc != 0) && ((a >> sh) == (base_of(2, sc) >> sh));
        if (m == 2 && sr == 3 && sp == 3 && sc == 0) begin
            tag = "R7";
            if (a[31:29] >= 3 && a[31:29] <= 6) return int'(a[31:29]) - 3;
            tag = "R10";
            return -1;
        end
        if (m == 1 && sp != 0 && sr == 0 && sc == 0) begin
            tag = hp ? "R3" : "R10";
            return hp ? int'(up) : -1;
        end
        if (m == 1 && sr != 0 && sp == 0 && sc == 0) begin
            tag = hr ? "R4" : "R10";
            return hr ? int'(ur) : -1;
        end
        if (m == 1 && sr != 0 && sp != 0 && sc == 0) begin
            tag = (hp || hr) ? "R5" : "R10";
            return hp ? 0 : (hr ? 1 : -1);
        end
        if (m == 1 && sc == 1 && ((sr != 0) != (sp != 0))) begin
            tag = (hc || hr || hp) ? "R6" : "R10";
            return hc ? 0 : ((hr || hp) ? 1 : -1);
        end
        tag = (hr || hp || hc) ? "R2" : "R10";
        return (hr || hp || hc) ? 0 : -1;
    endfunction

    // Drive one vector at a falling edge and check it at the next one (R9 latency).
    task automatic run_vec(input logic [31:0] a, input logic v);
        string tag;
        int e;
        logic [3:0] ecs;
        logic emiss, emux;
        tag = "R9";
        e = v ? ref_cs(mode, map, a, tag) : -1;
        addr = a;
        vld = v;
        @(negedge clk);
        ecs = 4'hF;
        if (e >= 0) ecs[e] = 1'b0;
        emiss = v && (e < 0);
        emux = (e < 0) ? 1'b0 : (per_en ? bmode[e] : bmode[0]);
        checks++;
        if (cs_n !== ecs || miss !== emiss) begin
            errors++;
            $display("FAIL %s mode=%0d map=%h addr=%h: cs_n=%b miss=%b expected cs_n=%b miss=%b",
                     tag, mode, map, a, cs_n, miss, ecs, emiss);
        end
        checks++;
        if (mux !== emux) begin
            errors++;
            $display("FAIL R8 mode=%0d map=%h addr=%h per=%b bm=%b: mux=%b expected %b",
                     mode, map, a, per_en, bmode, mux, emux);
        end
        checks++;
        if ($countones(~cs_n) > 1) begin
            errors++;
            $display("FAIL R12 cs_n=%b expected at most one low", cs_n);
        end
    endtask

    task automatic check_reset_state(input string when);
        checks++;
        if (cs_n !== 4'hF || miss !== 1'b0 || mux !== 1'b0) begin
            errors++;
            $display("FAIL R11 %s: cs_n=%b miss=%b mux=%b expected cs_n=1111 miss=0 mux=0",
                     when, cs_n, miss, mux);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pts [15];
        logic [31:0] qpts [8];
        qpts = '{32'h6000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hA000_0010,
                 32'hC000_0000, 32'hDFFF_FFFF, 32'hE000_0000, 32'h0000_0000};
        // R11: reset state with a valid hitting address present
        vld = 1'b1; addr = 32'h6000_0000; mode = 2'd2; map = 12'h033;
        repeat (3) @(negedge clk);
        check_reset_state("during reset");
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 64; s++) begin
                for (int z = 0; z < 4; z++) begin
                    logic [1:0] zr, zp, zc;
                    zr = 2'(z); zp = 2'(z + 1); zc = 2'(z + 2);
                    mode = 2'(m);
                    // R1 layout: {code size, code sel, per size, per sel, ram size, ram sel}
                    map = {zc, 2'(s >> 4), zp, 2'(s >> 2), zr, 2'(s)};
                    bmode = 4'(s + z);
                    per_en = s[0] ^ z[0];
                    for (int k = 0; k < 3; k++) begin
                        logic [31:0] b, sz;
                        logic [1:0] zz;
                        zz = (k == 0) ? zr : ((k == 1) ? zp : zc);
                        b = base_of(k, map[k*4 +: 2]);
                        sz = 32'd1 << shift_of(zz);
                        pts[k*5+0] = b;
                        pts[k*5+1] = b + (sz >> 1) - 1;
                        pts[k*5+2] = b + (sz >> 1);
                        pts[k*5+3] = b + sz - 1;
                        pts[k*5+4] = b + sz;
                    end
                    foreach (pts[i]) run_vec(pts[i], 1'b1);
                    foreach (qpts[i]) run_vec(qpts[i], 1'b1);
                    run_vec(pts[0], 1'b0);
                end
            end
        end
        // R11: synchronous reset while a hit is presented
        mode = 2'd0; map = 12'h001; addr = 32'h6000_0000; vld = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("mid-run reset");
        rst_n = 1'b1;
        run_vec(32'h6000_0000, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule